// File: doc/BRIEF.md
# Task Priority Interrupt Gate

This block holds the architectural task-priority value that software uses to hold off low-priority external interrupts. The interrupt arbiter presents the highest pending vector. The block compares that vector's priority class with the stored task-priority class and says whether the vector may be delivered. A vector whose class is at or below the stored class is held back. A vector whose class is above it is let through.

Software reaches the value through a 64-bit control-register port. Every access carries the requester's privilege level. An access from a privilege level other than 0 is refused with a one-cycle general-protection fault pulse. A write that sets any bit above the implemented four is refused in the same way. A refused access changes nothing. An accepted write takes effect on the next clock edge and is copied to the local interrupt controller's own task-priority register through a mirror strobe. The gate only applies while the local controller is enabled. The controller-enable flag lives here, is set at reset and is updated through its own write strobe. While the controller is disabled, legal writes are dropped and no masking is done.

Top module: `tpr_gate`

## Requirements
- R1: After reset the task-priority value is 0, the controller-enable flag is 1, and `gp_fault`, `rd_valid` and `mirror_wr` are 0.
- R2: While enabled and `pend_valid` is 1, `deliver_ok` is 1 exactly when the class `pend_vector[7:4]` is strictly greater than the stored 4-bit task-priority value. This output is combinational within the same cycle.
- R3: A stored value of 0 passes every vector whose class is 1 to 15. A stored value of 15 blocks every vector.
- R4: A write (`cr_wr`=1) at privilege 0, with `cr_wdata[63:4]` all zero and the controller enabled, stores `cr_wdata[3:0]`. The new value governs `deliver_ok` from the cycle after the request.
- R5: A write with any of `cr_wdata[63:4]` nonzero raises `gp_fault` for exactly the one cycle after the request and leaves the stored value unchanged.
- R6: Any access with `cr_cpl` not 0 raises `gp_fault` in the cycle after the request. It writes nothing, mirrors nothing and produces no read response.
- R7: A read (`cr_wr`=0) at privilege 0 raises `rd_valid` in the cycle after the request. `rd_data` then carries the stored value in bits 3:0, and bits 63:4 are 0.
- R8: Every accepted write raises `mirror_wr` for one cycle, in the cycle after the request. `mirror_val` equals the newly stored value.
- R9: While the controller is disabled, a write that passes the privilege and reserved-bit checks is ignored: no update, no mirror, no fault. In that state `deliver_ok` equals `pend_valid`.
- R10: `ctl_en_we`=1 loads `ctl_en_d` into the controller-enable flag on the next edge.
- R11: `deliver_ok` is 0 whenever `pend_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_req | input | 1 | Control-register access request |
| cr_wr | input | 1 | 1 = write, 0 = read |
| cr_cpl | input | 2 | Privilege level of the requester |
| cr_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Read data, zero-extended |
| gp_fault | output | 1 | General-protection fault pulse |
| ctl_en_we | input | 1 | Controller-enable write strobe |
| ctl_en_d | input | 1 | Controller-enable write value |
| mirror_wr | output | 1 | Copy strobe to the controller's task-priority register |
| mirror_val | output | 4 | Value being copied |
| pend_valid | input | 1 | A pending vector is presented |
| pend_vector | input | 8 | Highest pending vector |
| deliver_ok | output | 1 | Pending vector may be delivered |

## Verification
The bench probes the class boundary: a vector whose class equals the stored value must be held back. A design comparing with greater-or-equal would wrongly let that class through. Writes that carry a single stray bit in the reserved range, or come from privilege 1 to 3, must fault and leave both the value and the mirror untouched. A design that checks only some bits, or that faults but still writes, gives itself away on the read that follows. Legal writes while the controller is disabled must vanish without a fault, and every vector must pass in that state. The bench also confirms that a new value governs delivery from the very next cycle.

// File: rtl/tpr_gate_pkg.sv
package tpr_gate_pkg;

  // Outcome of one control-register access, decided combinationally.
  typedef struct packed {
    logic fault;
    logic do_write;
    logic do_read;
  } acc_dec_t;

endpackage

// File: rtl/tpr_access_check.sv
module tpr_access_check
  import tpr_gate_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2
) (
  input  logic              req,
  input  logic              wr,
  input  logic [PL_W-1:0]   cpl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ctl_en,
  output acc_dec_t          dec
);

  localparam int RSVD_W = DATA_W - CLASS_W;

  function automatic logic rsvd_set(input logic [DATA_W-1:0] d);
    return |d[DATA_W-1:CLASS_W];
  endfunction

  function automatic logic priv_ok(input logic [PL_W-1:0] p);
    return p == '0;
  endfunction

  logic priv_bad;
  logic rsvd_bad;

  always_comb begin
    priv_bad     = req && !priv_ok(cpl);
    rsvd_bad     = req && wr && rsvd_set(wdata);
    dec.fault    = priv_bad || rsvd_bad;
    dec.do_write = req && wr && !dec.fault && ctl_en;
    dec.do_read  = req && !wr && !dec.fault;
  end

  logic unused_w;
  assign unused_w = (RSVD_W > 0) ? 1'b0 : 1'b0;

endmodule

// File: rtl/tpr_class_cmp.sv
module tpr_class_cmp #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic               valid,
  input  logic [VEC_W-1:0]   vector,
  input  logic [CLASS_W-1:0] tpr,
  input  logic               en,
  output logic               pass
);

  function automatic logic [CLASS_W-1:0] vec_class(input logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: CLASS_W];
  endfunction

  function automatic logic above(input logic [CLASS_W-1:0] c,
                                 input logic [CLASS_W-1:0] t);
    return c > t;
  endfunction

  assign pass = valid && (!en || above(vec_class(vector), tpr));

endmodule

// File: rtl/tpr_gate.sv
module tpr_gate
  import tpr_gate_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cr_req,
  input  logic               cr_wr,
  input  logic [PL_W-1:0]    cr_cpl,
  input  logic [DATA_W-1:0]  cr_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               gp_fault,
  input  logic               ctl_en_we,
  input  logic               ctl_en_d,
  output logic               mirror_wr,
  output logic [CLASS_W-1:0] mirror_val,
  input  logic               pend_valid,
  input  logic [VEC_W-1:0]   pend_vector,
  output logic               deliver_ok
);

  localparam int PAD_W = DATA_W - CLASS_W;

  logic [CLASS_W-1:0] tpr_q;
  logic               en_q;
  acc_dec_t           acc_dec;

  // Named events for the checker
  logic acc_fault;
  logic acc_write;
  logic acc_read;

  tpr_access_check #(
    .DATA_W (DATA_W),
    .CLASS_W(CLASS_W),
    .PL_W   (PL_W)
  ) u_acc (
    .req   (cr_req),
    .wr    (cr_wr),
    .cpl   (cr_cpl),
    .wdata (cr_wdata),
    .ctl_en(en_q),
    .dec   (acc_dec)
  );

  assign acc_fault = acc_dec.fault;
  assign acc_write = acc_dec.do_write;
  assign acc_read  = acc_dec.do_read;

  tpr_class_cmp #(
    .VEC_W  (VEC_W),
    .CLASS_W(CLASS_W)
  ) u_cmp (
    .valid (pend_valid),
    .vector(pend_vector),
    .tpr   (tpr_q),
    .en    (en_q),
    .pass  (deliver_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q      <= '0;
      en_q       <= 1'b1;
      gp_fault   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      mirror_wr  <= 1'b0;
      mirror_val <= '0;
    end else begin
      gp_fault  <= acc_fault;
      rd_valid  <= acc_read;
      mirror_wr <= acc_write;
      if (acc_read)  rd_data <= {{PAD_W{1'b0}}, tpr_q};
      if (acc_write) begin
        tpr_q      <= cr_wdata[CLASS_W-1:0];
        mirror_val <= cr_wdata[CLASS_W-1:0];
      end
      if (ctl_en_we) en_q <= ctl_en_d;
    end
  end

endmodule

// File: rtl/tpr_gate_chk.sv
module tpr_gate_chk #(
  parameter int DATA_W  = 64,
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cr_req,
  input logic               cr_wr,
  input logic [PL_W-1:0]    cr_cpl,
  input logic [DATA_W-1:0]  cr_wdata,
  input logic               rd_valid,
  input logic [DATA_W-1:0]  rd_data,
  input logic               gp_fault,
  input logic               mirror_wr,
  input logic [CLASS_W-1:0] mirror_val,
  input logic               pend_valid,
  input logic [VEC_W-1:0]   pend_vector,
  input logic               deliver_ok,
  input logic [CLASS_W-1:0] tpr_q,
  input logic               en_q,
  input logic               acc_fault
);

  AST_BLOCK_LOW_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && en_q && (pend_vector[VEC_W-1 -: CLASS_W] <= tpr_q)) |-> !deliver_ok); // R2

  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && cr_wr && (|cr_wdata[DATA_W-1:CLASS_W])) |=> gp_fault); // R5

  AST_FAULT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |=> ($stable(tpr_q) && !mirror_wr)); // R5

  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && (cr_cpl != '0)) |=> (gp_fault && !rd_valid)); // R6

  AST_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-1:CLASS_W] == '0)); // R7

  AST_MIRROR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_wr |-> (mirror_val == tpr_q)); // R8

  AST_DISABLED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (deliver_ok == pend_valid)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> !deliver_ok); // R11

endmodule

bind tpr_gate tpr_gate_chk #(
  .DATA_W (DATA_W),
  .CLASS_W(CLASS_W),
  .PL_W   (PL_W),
  .VEC_W  (VEC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cr_req     (cr_req),
  .cr_wr      (cr_wr),
  .cr_cpl     (cr_cpl),
  .cr_wdata   (cr_wdata),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .gp_fault   (gp_fault),
  .mirror_wr  (mirror_wr),
  .mirror_val (mirror_val),
  .pend_valid (pend_valid),
  .pend_vector(pend_vector),
  .deliver_ok (deliver_ok),
  .tpr_q      (tpr_q),
  .en_q       (en_q),
  .acc_fault  (acc_fault)
);

// File: tb/tpr_gate_bench.sv
`timescale 1ns/1ps
module tpr_gate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cr_req = 1'b0;
  logic        cr_wr = 1'b0;
  logic [1:0]  cr_cpl = '0;
  logic [63:0] cr_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        gp_fault;
  logic        ctl_en_we = 1'b0;
  logic        ctl_en_d = 1'b0;
  logic        mirror_wr;
  logic [3:0]  mirror_val;
  logic        pend_valid = 1'b0;
  logic [7:0]  pend_vector = '0;
  logic        deliver_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] tpr_m = '0;
  bit         en_m  = 1;

  always #2.5 clk = ~clk;

  tpr_gate u_tpr_gate (
    .clk(clk), .rst_n(rst_n),
    .cr_req(cr_req), .cr_wr(cr_wr), .cr_cpl(cr_cpl), .cr_wdata(cr_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .gp_fault(gp_fault),
    .ctl_en_we(ctl_en_we), .ctl_en_d(ctl_en_d),
    .mirror_wr(mirror_wr), .mirror_val(mirror_val),
    .pend_valid(pend_valid), .pend_vector(pend_vector), .deliver_ok(deliver_ok)
  );

  function automatic bit exp_pass(bit v, logic [7:0] vec, logic [3:0] t, bit en);
    if (!v) return 0;
    if (!en) return 1;
    return (vec >> 4) > {4'b0, t};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(bit v, logic [7:0] vec, string req);
    bit e;
    pend_valid = v;
    pend_vector = vec;
    #0.5;
    e = exp_pass(v, vec, tpr_m, en_m);
    chk(deliver_ok == e, req, {63'b0, deliver_ok}, {63'b0, e});
  endtask

  // Drive at negedge, outputs checked at the following negedge.
  task automatic access(bit wr, logic [1:0] cpl, logic [63:0] d);
    bit flt, wok, rok;
    flt = (cpl != 0) || (wr && (d[63:4] != 0));
    wok = wr && !flt && en_m;
    rok = !wr && !flt;
    cr_req = 1; cr_wr = wr; cr_cpl = cpl; cr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cr_req = 0;
    if (wok) tpr_m = d[3:0];
    chk(gp_fault == flt, flt ? ((cpl != 0) ? "R6" : "R5") : "R9", {63'b0, gp_fault}, {63'b0, flt});
    chk(mirror_wr == wok, "R8", {63'b0, mirror_wr}, {63'b0, wok});
    if (wok) chk(mirror_val == tpr_m, "R8", {60'b0, mirror_val}, {60'b0, tpr_m});
    chk(rd_valid == rok, "R7", {63'b0, rd_valid}, {63'b0, rok});
    if (rok) chk(rd_data == {60'b0, tpr_m}, "R7", rd_data, {60'b0, tpr_m});
  endtask

  task automatic set_en(bit v);
    ctl_en_we = 1; ctl_en_d = v;
    @(posedge clk);
    @(negedge clk);
    ctl_en_we = 0;
    en_m = v;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(gp_fault == 0 && rd_valid == 0 && mirror_wr == 0, "R1", {61'b0, gp_fault, rd_valid, mirror_wr}, 0);
    access(0, 0, 0);   // R1: value reads back as 0
    probe(1, 8'h10, "R1");  // enabled after reset, class 1 > 0 passes
    // R3 corners
    for (int c = 0; c < 16; c++) probe(1, {c[3:0], 4'h7}, "R3");
    access(1, 0, 64'hF);  // R4
    for (int c = 0; c < 16; c++) probe(1, {c[3:0], 4'h0}, "R3");
    // R2 boundary with class 8
    access(1, 0, 64'h8);
    probe(1, 8'h8F, "R2");
    probe(1, 8'h90, "R2");
    probe(0, 8'hF0, "R11");
    // R5 single stray reserved bits
    access(1, 0, 64'h10 | 64'h3);
    access(1, 0, 64'h8000_0000_0000_0002);
    access(0, 0, 0);
    // R6 other privilege levels
    for (int p = 1; p < 4; p++) begin
      access(1, p[1:0], 64'h2);
      access(0, p[1:0], 64'h0);
    end
    probe(1, 8'h8F, "R6");
    // R9 disabled controller
    set_en(0);
    access(1, 0, 64'h1);
    probe(1, 8'h00, "R9");
    probe(0, 8'hFF, "R9");
    set_en(1);  // R10
    access(0, 0, 0);
    probe(1, 8'h8F, "R10");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) set_en($urandom_range(0, 1));
      else begin
        logic [63:0] d = {60'b0, 4'($urandom)};
        logic [1:0] p = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b0;
        if ($urandom_range(0, 4) == 0) d[6'($urandom_range(4, 63))] = 1'b1;
        access(op < 6, p, d);
      end
      probe($urandom_range(0, 7) != 0, 8'($urandom), "R2");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule